// File: doc/BRIEF.md
# Window Watchdog with Lead Time

This block supervises a host processor by demanding a periodic trigger inside a timed window. All of its timing is counted in periods of a slow supervision oscillator, which reaches the block as a single-cycle enable pulse (`osc_tick`) in the logic clock domain. After any reset, and after every reset pulse it raises itself, it first grants a long lead period in which the first trigger is due. It then runs a closed window, in which a trigger is forbidden, followed by an open window, in which a trigger is expected. An accepted trigger in the open window starts the next closed window.

A trigger is a pulse on either of two inputs: a low-going pulse on `trig_n` or a high-going pulse on `trig_p`. A pulse counts only if it stays active long enough, which filters glitches. A trigger in the closed window, or no trigger before the open window or the lead period runs out, produces an active-low reset pulse of fixed length on `rst_out_n` and sets a sticky fault flag that software clears. Holding `wd_off` high parks the block in a quiet state for low-power modes. Clearing `wd_off` restarts it at the lead period.

Top module: `win_watchdog`

## Requirements
- R1: After `rst_n` is released, `rst_out_n` is 1 and `wd_fault` is 0. Reset release passes through two synchronizing flops, so the lead period counts ticks from the third clock edge on. With a tick on every clock and no trigger, `rst_out_n` falls on clock edge LEAD_TICKS+2 after release.
- R2: A reset pulse holds `rst_out_n` at 0 for exactly PULSE_TICKS ticks. The block then re-enters the lead period, and triggers are ignored while the pulse lasts.
- R3: The trigger input is active while `trig_n`=0 or `trig_p`=1. Both inputs pass through two synchronizing flops. A pulse is accepted once, when it has been sampled active on MIN_WIDTH consecutive clocks; a raw pulse first seen at clock edge m takes effect at edge m+MIN_WIDTH+2. A shorter pulse has no effect.
- R4: A trigger accepted during the lead period starts a closed window of SHUT_TICKS ticks.
- R5: A trigger accepted during the closed window, including its last tick, starts a reset pulse on the same edge.
- R6: The open window of OPEN_TICKS ticks follows the closed window. A trigger accepted there restarts the closed window. Expiry of the open window or of the lead period starts a reset pulse.
- R7: While `wd_off` is 1, `rst_out_n` stays 1 and all triggers are ignored. On the first edge with `wd_off` at 0, the lead period restarts from zero.
- R8: `wd_fault` is set on the edge where a reset pulse starts and then holds. `flag_clr`=1 clears it on the next edge, but a pulse start on that same edge wins.
- R9: Time advances only on clocks where `osc_tick` is 1. With no ticks, no window expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| osc_tick | input | 1 | One-clock enable per supervision oscillator period |
| wd_off | input | 1 | 1 = low-power mode, watchdog parked |
| trig_n | input | 1 | Trigger, active low |
| trig_p | input | 1 | Trigger, active high |
| flag_clr | input | 1 | Clears the sticky fault flag |
| rst_out_n | output | 1 | Active-low reset pulse to the host |
| wd_fault | output | 1 | Sticky flag: a reset pulse has started |

## Verification
The bench places triggers on the last tick of the closed window and on the first tick of the open window. An off-by-one in the window boundary would either accept the early trigger or reset on a legal one. It sends a pulse one sample shorter than the minimum width, which a filter with a loose compare would accept and so skip the expected lead-time reset. It also drives the low-active trigger input, parks the block in low-power mode with triggers present, and withholds ticks. Wrong polarity handling, a reset raised while parked, or time counted on every clock would each move or add a reset edge that the scoreboard does not expect.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [2:0] {
    WD_OFF   = 3'd0,
    WD_LEAD  = 3'd1,
    WD_SHUT  = 3'd2,
    WD_OPEN  = 3'd3,
    WD_PULSE = 3'd4
  } wd_state_e;
endpackage

// File: rtl/wdg_rst_sync.sv
module wdg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign srst_n = s2_q;
endmodule

// File: rtl/wdg_trig_qual.sv
module wdg_trig_qual #(
  parameter int MIN_WIDTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_n,
  input  logic trig_p,
  output logic trig_ok
);
  localparam int CW = $clog2(MIN_WIDTH + 1);

  logic          n_s1_q, n_s2_q, p_s1_q, p_s2_q;
  logic          act;
  logic [CW-1:0] wcnt_q, wcnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_s1_q <= 1'b1;
      n_s2_q <= 1'b1;
      p_s1_q <= 1'b0;
      p_s2_q <= 1'b0;
    end else begin
      n_s1_q <= trig_n;
      n_s2_q <= n_s1_q;
      p_s1_q <= trig_p;
      p_s2_q <= p_s1_q;
    end
  end

  assign act = !n_s2_q || p_s2_q;

  // width counter saturates so one pulse yields one acceptance
  always_comb begin
    wcnt_d = wcnt_q;
    if (!act)
      wcnt_d = '0;
    else if (wcnt_q != CW'(MIN_WIDTH))
      wcnt_d = wcnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt_q <= '0;
    else        wcnt_q <= wcnt_d;
  end

  assign trig_ok = act && (wcnt_q == CW'(MIN_WIDTH - 1));
endmodule

// File: rtl/wdg_seq.sv
module wdg_seq
  import wdg_pkg::*;
#(
  parameter int LEAD_TICKS  = 3922,
  parameter int SHUT_TICKS  = 800,
  parameter int OPEN_TICKS  = 840,
  parameter int PULSE_TICKS = 157
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      wd_off,
  input  logic      trig_ok,
  output wd_state_e state_o,
  output logic      pulse_start
);
  localparam int MAX_AB = (LEAD_TICKS > SHUT_TICKS) ? LEAD_TICKS : SHUT_TICKS;
  localparam int MAX_CD = (OPEN_TICKS > PULSE_TICKS) ? OPEN_TICKS : PULSE_TICKS;
  localparam int MAXT   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = $clog2(MAXT + 1);

  wd_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d, lim_m1;
  logic          expire;

  always_comb begin
    case (state_q)
      WD_LEAD:  lim_m1 = CW'(LEAD_TICKS - 1);
      WD_SHUT:  lim_m1 = CW'(SHUT_TICKS - 1);
      WD_OPEN:  lim_m1 = CW'(OPEN_TICKS - 1);
      WD_PULSE: lim_m1 = CW'(PULSE_TICKS - 1);
      default:  lim_m1 = '0;
    endcase
  end

  assign expire = tick && (cnt_q == lim_m1);

  always_comb begin
    state_d     = state_q;
    cnt_d       = tick ? cnt_q + CW'(1) : cnt_q;
    pulse_start = 1'b0;
    if (wd_off) begin
      state_d = WD_OFF;
      cnt_d   = '0;
    end else begin
      case (state_q)
        WD_OFF: begin
          state_d = WD_LEAD;
          cnt_d   = '0;
        end
        WD_LEAD, WD_OPEN: begin
          if (trig_ok) begin
            state_d = WD_SHUT;
            cnt_d   = '0;
          end else if (expire) begin
            state_d     = WD_PULSE;
            cnt_d       = '0;
            pulse_start = 1'b1;
          end
        end
        WD_SHUT: begin
          // a trigger in the closed window wins over its expiry
          if (trig_ok) begin
            state_d     = WD_PULSE;
            cnt_d       = '0;
            pulse_start = 1'b1;
          end else if (expire) begin
            state_d = WD_OPEN;
            cnt_d   = '0;
          end
        end
        WD_PULSE: begin
          if (expire) begin
            state_d = WD_LEAD;
            cnt_d   = '0;
          end
        end
        default: begin
          state_d = WD_LEAD;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WD_LEAD;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wdg_pkg::*;
#(
  parameter int LEAD_TICKS  = 3922,
  parameter int SHUT_TICKS  = 800,
  parameter int OPEN_TICKS  = 840,
  parameter int PULSE_TICKS = 157,
  parameter int MIN_WIDTH   = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic wd_off,
  input  logic trig_n,
  input  logic trig_p,
  input  logic flag_clr,
  output logic rst_out_n,
  output logic wd_fault
);
  logic      srst_n;
  logic      trig_hit;
  logic      pulse_start;
  logic      fault_q, fault_d;
  wd_state_e st;

  wdg_rst_sync u_rsync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  wdg_trig_qual #(.MIN_WIDTH(MIN_WIDTH)) u_qual (
    .clk     (clk),
    .rst_n   (srst_n),
    .trig_n  (trig_n),
    .trig_p  (trig_p),
    .trig_ok (trig_hit)
  );

  wdg_seq #(
    .LEAD_TICKS  (LEAD_TICKS),
    .SHUT_TICKS  (SHUT_TICKS),
    .OPEN_TICKS  (OPEN_TICKS),
    .PULSE_TICKS (PULSE_TICKS)
  ) u_seq (
    .clk         (clk),
    .rst_n       (srst_n),
    .tick        (osc_tick),
    .wd_off      (wd_off),
    .trig_ok     (trig_hit),
    .state_o     (st),
    .pulse_start (pulse_start)
  );

  always_comb begin
    fault_d = fault_q;
    if (pulse_start)   fault_d = 1'b1;
    else if (flag_clr) fault_d = 1'b0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) fault_q <= 1'b0;
    else         fault_q <= fault_d;
  end

  assign rst_out_n = (st != WD_PULSE);
  assign wd_fault  = fault_q;
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk
  import wdg_pkg::*;
#(
  parameter int PULSE_TICKS = 157
) (
  input logic      clk,
  input logic      rst_n,
  input logic      osc_tick,
  input logic      wd_off,
  input logic      flag_clr,
  input logic      rst_out_n,
  input logic      wd_fault,
  input wd_state_e st,
  input logic      trig_hit
);
  int low_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         low_ticks <= 0;
    else if (rst_out_n) low_ticks <= 0;
    else if (osc_tick)  low_ticks <= low_ticks + 1;
  end

  // R2
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_out_n) && !$past(wd_off)) |-> (low_ticks == PULSE_TICKS));

  // R2
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_ticks <= PULSE_TICKS);

  // R8
  fault_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_n) |-> wd_fault);

  // R8
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_fault && !flag_clr) |=> wd_fault);

  // R7
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_off |=> rst_out_n);

  // R5
  early_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WD_SHUT && trig_hit && !wd_off) |=> !rst_out_n);

  // R4
  lead_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WD_LEAD && trig_hit && !wd_off) |=> (rst_out_n && st == WD_SHUT));
endmodule

bind win_watchdog wdg_chk #(.PULSE_TICKS(PULSE_TICKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .osc_tick  (osc_tick),
  .wd_off    (wd_off),
  .flag_clr  (flag_clr),
  .rst_out_n (rst_out_n),
  .wd_fault  (wd_fault),
  .st        (st),
  .trig_hit  (trig_hit)
);

// File: tb/tb_win_watchdog.sv
module tb_win_watchdog;
  localparam int LT = 40;
  localparam int ST = 10;
  localparam int OT = 12;
  localparam int PT = 6;
  localparam int MW = 3;

  logic clk, rst_n, osc_tick, wd_off, trig_n, trig_p, flag_clr;
  logic rst_out_n, wd_fault;

  win_watchdog #(
    .LEAD_TICKS(LT), .SHUT_TICKS(ST), .OPEN_TICKS(OT),
    .PULSE_TICKS(PT), .MIN_WIDTH(MW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .wd_off(wd_off),
    .trig_n(trig_n), .trig_p(trig_p), .flag_clr(flag_clr),
    .rst_out_n(rst_out_n), .wd_fault(wd_fault)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int cyc;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  typedef struct {
    int    when;
    logic  lvl;
    string req;
  } ev_t;
  ev_t expq[$];

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_edge(input int when, input logic lvl, input string req);
    ev_t e;
    e.when = when;
    e.lvl  = lvl;
    e.req  = req;
    expq.push_back(e);
  endtask

  // monitor: every change of rst_out_n must match the next queued edge
  logic prev;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev = rst_out_n;
    end else if (rst_out_n !== prev) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R7", "unexpected reset edge at cycle", cyc, -1);
      end else begin
        ev_t e;
        e = expq.pop_front();
        chk(cyc == e.when && rst_out_n == e.lvl, e.req, "reset edge cycle",
            cyc, e.when);
      end
      prev = rst_out_n;
    end
  end

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    expq.delete();
    rst_n = 1'b1;
  endtask

  task automatic end_test(input int n, input string req);
    wait_cyc(n);
    chk(expq.size() == 0, req, "missing reset edges", expq.size(), 0);
  endtask

  task automatic trig_at(input int m, input bit use_p, input int width);
    wait_cyc(m);
    if (use_p) trig_p = 1'b1;
    else       trig_n = 1'b0;
    repeat (width) @(negedge clk);
    trig_p = 1'b0;
    trig_n = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; osc_tick = 1'b1; wd_off = 1'b0;
    trig_n = 1'b1; trig_p = 1'b0; flag_clr = 1'b0;
    do_reset();

    // R1 reset state
    chk(rst_out_n == 1'b1, "R1", "rst_out_n after reset", int'(rst_out_n), 1);
    chk(wd_fault == 1'b0, "R1", "wd_fault after reset", int'(wd_fault), 0);

    // R1 R2: no trigger, lead expiry, pulse, lead again
    expect_edge(LT + 2, 1'b0, "R1");
    expect_edge(LT + 2 + PT, 1'b1, "R2");
    expect_edge(LT + 2 + PT + LT, 1'b0, "R2");
    expect_edge(LT + 2 + PT + LT + PT, 1'b1, "R2");
    wait_cyc(LT + 1);
    chk(wd_fault == 1'b0, "R8", "fault before pulse", int'(wd_fault), 0);
    wait_cyc(LT + 3);
    chk(wd_fault == 1'b1, "R8", "fault at pulse", int'(wd_fault), 1);
    end_test(100, "R2");
    chk(wd_fault == 1'b1, "R8", "fault sticky", int'(wd_fault), 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk(wd_fault == 1'b0, "R8", "fault cleared", int'(wd_fault), 0);

    // R4 R6: lead trigger, open-window trigger, then open expiry
    do_reset();
    expect_edge(55, 1'b0, "R6");
    expect_edge(61, 1'b1, "R6");
    trig_at(10, 1'b1, MW);
    trig_at(28, 1'b1, MW);
    end_test(64, "R4");

    // R3: same sequence on the low-active input
    do_reset();
    expect_edge(55, 1'b0, "R3");
    expect_edge(61, 1'b1, "R3");
    trig_at(10, 1'b0, MW);
    trig_at(28, 1'b0, MW);
    end_test(64, "R3");

    // R5: trigger well inside the closed window
    do_reset();
    expect_edge(20, 1'b0, "R5");
    expect_edge(26, 1'b1, "R5");
    trig_at(10, 1'b1, MW);
    trig_at(15, 1'b1, MW);
    end_test(30, "R5");

    // R5: trigger on the last tick of the closed window
    do_reset();
    expect_edge(25, 1'b0, "R5");
    expect_edge(31, 1'b1, "R5");
    trig_at(10, 1'b1, MW);
    trig_at(20, 1'b1, MW);
    end_test(34, "R5");

    // R6: trigger on the first tick of the open window
    do_reset();
    expect_edge(48, 1'b0, "R6");
    expect_edge(54, 1'b1, "R6");
    trig_at(10, 1'b1, MW);
    trig_at(21, 1'b1, MW);
    end_test(57, "R6");

    // R3: pulse one sample short is ignored
    do_reset();
    expect_edge(LT + 2, 1'b0, "R3");
    expect_edge(LT + 2 + PT, 1'b1, "R3");
    trig_at(10, 1'b1, MW - 1);
    end_test(50, "R3");

    // R7: parked in low-power mode, then lead restarts
    do_reset();
    wait_cyc(5);
    wd_off = 1'b1;
    trig_at(60, 1'b1, MW);
    wait_cyc(150);
    chk(rst_out_n == 1'b1, "R7", "rst_out_n while off", int'(rst_out_n), 1);
    wd_off = 1'b0;
    expect_edge(151 + LT, 1'b0, "R7");
    expect_edge(151 + LT + PT, 1'b1, "R7");
    end_test(200, "R7");

    // R9: no ticks, no time
    osc_tick = 1'b0;
    do_reset();
    wait_cyc(100);
    chk(rst_out_n == 1'b1, "R9", "rst_out_n without ticks", int'(rst_out_n), 1);
    osc_tick = 1'b1;
    expect_edge(100 + LT, 1'b0, "R9");
    expect_edge(100 + LT + PT, 1'b1, "R9");
    end_test(150, "R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule